// File: doc/BRIEF.md
# Bidirectional Handshaked Parallel Port

This block is one 8-bit parallel port whose pins carry data in both directions. Each direction has its own handshake. The peripheral controls two active-low lines: an acknowledge line that calls for outbound data and a strobe line that hands over inbound data. Both lines rest high when idle. In that state the port keeps its drivers off, so the peripheral may drive the pins safely.

For the outbound direction, the host writes a byte into an output register. The port drives that byte onto the pins only while the synchronized acknowledge is low. Once acknowledge returns high, the drivers turn off and the byte no longer appears on the pins. For the inbound direction, the peripheral puts a byte on the pins and pulls strobe low. The falling edge latches the pins into an input register, which the host then reads.

Each direction has its own full flag. Both handshake lines pass through a synchronizer before any logic uses them. Driver enable is never asserted while the synchronized strobe is low.

Top module: `bidir_hs_port`

## Requirements
- R1: After reset, pad_oe_o is 0, pad_o is 0x00, out_full_o is 0, in_full_o is 0 and rd_data_o is 0x00.
- R2: A host write (wr_en_i high at a clock edge) loads wr_data_i into the output register and sets out_full_o in the following cycle.
- R3: pad_oe_o is 1 exactly when the acknowledge level, delayed by two clock edges through the synchronizer, is low and the similarly delayed strobe is high. While pad_oe_o is 1, pad_o equals the output register.
- R4: While pad_oe_o is 0, pad_o reads 0x00, so the written pattern does not appear once acknowledge has risen again.
- R5: out_full_o clears one cycle after a falling edge of the synchronized acknowledge. A host write in that same cycle takes priority and keeps the flag set.
- R6: A falling edge of the synchronized strobe captures pad_i into the input register (rd_data_o) and sets in_full_o one cycle later.
- R7: A host read (rd_en_i high) clears in_full_o in the following cycle. A strobe capture in that same cycle takes priority and keeps the flag set.
- R8: While the synchronized strobe is low, pad_oe_o is 0, even if acknowledge is also low.
- R9: The two directions are independent. Host writes do not change rd_data_o, and strobe captures do not change the output register or out_full_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe for the output register |
| wr_data_i | input | 8 | Host write data |
| rd_en_i | input | 1 | Host read acknowledge; clears the input full flag |
| rd_data_o | output | 8 | Input register contents |
| ack_ni | input | 1 | Peripheral acknowledge, active low, asynchronous |
| stb_ni | input | 1 | Peripheral strobe, active low, asynchronous |
| pad_i | input | 8 | Pin values as seen from the pins |
| pad_o | output | 8 | Pin drive value (0x00 when not driving) |
| pad_oe_o | output | 1 | Pin driver enable, active high |
| out_full_o | output | 1 | Output register holds data not yet taken |
| in_full_o | output | 1 | Input register holds data not yet read |

## Verification
The bench exercises the outbound path with several patterns:
- idle lines, to show the drivers stay off;
- an acknowledge-low window, to show the enable latency and the driven byte;
- a write made inside that window, to show the pins follow the register;
- the rise of acknowledge, to show the pins release and read zero.

The inbound path is tried with a strobe pulse while the peripheral drives a byte. A simultaneous read and capture, and a simultaneous write and acknowledge fall, separate the two priority rules. A deliberate protocol violation, with acknowledge low inside a strobe-low window, shows that the strobe gating overrides acknowledge. A behavioural model compares every output on every cycle, and a bus model flags any cycle in which port and peripheral drive the pins at once.

// File: rtl/bhp_pkg.sv
package bhp_pkg;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned SYNC_DEPTH = 2;

  typedef enum logic [0:0] {
    HS_ACK = 1'b0,
    HS_STB = 1'b1
  } hs_line_e;
endpackage

// File: rtl/bhp_sync.sv
module bhp_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] fell_o
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg[0] <= '1;
    else         stg[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[g] <= '1;
      else         stg[g] <= stg[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= stg[STAGES-1];
  end

  assign q_o    = stg[STAGES-1];
  assign fell_o = prev_q & ~stg[STAGES-1];
endmodule

// File: rtl/bhp_out_path.sv
module bhp_out_path #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          ack_s_i,
  input  logic          ack_fell_i,
  input  logic          stb_s_i,
  output logic          full_o,
  output logic [DW-1:0] pad_o,
  output logic          pad_oe_o
);
  logic [DW-1:0] out_q;
  logic          full_q;
  logic          drive;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      full_q <= 1'b0;
    end else begin
      if (wr_en_i) out_q <= wr_data_i;
      // write wins over a same-cycle take
      if (wr_en_i)         full_q <= 1'b1;
      else if (ack_fell_i) full_q <= 1'b0;
    end
  end

  assign drive    = ~ack_s_i & stb_s_i;
  assign pad_oe_o = drive;
  assign pad_o    = drive ? out_q : '0;
  assign full_o   = full_q;
endmodule

// File: rtl/bhp_in_path.sv
module bhp_in_path #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stb_fell_i,
  input  logic [DW-1:0] pad_i,
  input  logic          rd_en_i,
  output logic          full_o,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] in_q;
  logic          full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q   <= '0;
      full_q <= 1'b0;
    end else begin
      if (stb_fell_i) in_q <= pad_i;
      // capture wins over a same-cycle read
      if (stb_fell_i)   full_q <= 1'b1;
      else if (rd_en_i) full_q <= 1'b0;
    end
  end

  assign full_o    = full_q;
  assign rd_data_o = in_q;
endmodule

// File: rtl/bidir_hs_port.sv
module bidir_hs_port
  import bhp_pkg::*;
#(
  parameter int unsigned DW     = DATA_W,
  parameter int unsigned STAGES = SYNC_DEPTH
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          ack_ni,
  input  logic          stb_ni,
  input  logic [DW-1:0] pad_i,
  output logic [DW-1:0] pad_o,
  output logic          pad_oe_o,
  output logic          out_full_o,
  output logic          in_full_o
);
  localparam int unsigned NLINES = 2;

  logic [NLINES-1:0] hs_raw, hs_s, hs_fell;

  assign hs_raw[HS_ACK] = ack_ni;
  assign hs_raw[HS_STB] = stb_ni;

  bhp_sync #(.W(NLINES), .STAGES(STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (hs_raw),
    .q_o    (hs_s),
    .fell_o (hs_fell)
  );

  bhp_out_path #(.DW(DW)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .ack_s_i    (hs_s[HS_ACK]),
    .ack_fell_i (hs_fell[HS_ACK]),
    .stb_s_i    (hs_s[HS_STB]),
    .full_o     (out_full_o),
    .pad_o      (pad_o),
    .pad_oe_o   (pad_oe_o)
  );

  bhp_in_path #(.DW(DW)) u_in (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stb_fell_i (hs_fell[HS_STB]),
    .pad_i      (pad_i),
    .rd_en_i    (rd_en_i),
    .full_o     (in_full_o),
    .rd_data_o  (rd_data_o)
  );
endmodule

// File: rtl/bhp_chk.sv
module bhp_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic          stb_ni,
  input logic          ack_fell,
  input logic          stb_fell,
  input logic [DW-1:0] pad_o,
  input logic          pad_oe_o,
  input logic          out_full_o,
  input logic [DW-1:0] rd_data_o
);
  p_write_sets_full_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> out_full_o);

  p_idle_pads_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pad_oe_o |-> pad_o == '0);

  p_full_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_full_o && !ack_fell) |=> out_full_o);

  p_no_drive_in_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stb_ni && !$past(stb_ni)) |=> !pad_oe_o);

  p_input_reg_steady_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_fell |=> $stable(rd_data_o));
endmodule

bind bidir_hs_port bhp_chk #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .stb_ni     (stb_ni),
  .ack_fell   (hs_fell[0]),
  .stb_fell   (hs_fell[1]),
  .pad_o      (pad_o),
  .pad_oe_o   (pad_oe_o),
  .out_full_o (out_full_o),
  .rd_data_o  (rd_data_o)
);

// File: tb/bidir_hs_port_test.sv
module bidir_hs_port_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       wr_en = 0, rd_en = 0;
  logic [7:0] wr_data = 0;
  logic       ack_n = 1, stb_n = 1;
  logic       periph_en = 0;
  logic [7:0] periph_data = 0;
  logic [7:0] pad_in;
  logic [7:0] pad_out, rd_data;
  logic       pad_oe, out_full, in_full;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  // bus model: pull-ups when nobody drives
  assign pad_in = periph_en ? periph_data : (pad_oe ? pad_out : 8'hFF);

  bidir_hs_port uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .ack_ni(ack_n), .stb_ni(stb_n),
    .pad_i(pad_in), .pad_o(pad_out), .pad_oe_o(pad_oe),
    .out_full_o(out_full), .in_full_o(in_full)
  );

  // reference model
  bit   qa[$], qs[$];
  logic [7:0] m_out, m_in;
  bit   m_of, m_if;

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qa = {1, 1, 1}; qs = {1, 1, 1};
      m_out = 0; m_in = 0; m_of = 0; m_if = 0;
    end else begin
      bit afell, sfell;
      afell = qa[1] == 0 && qa[2] == 1;
      sfell = qs[1] == 0 && qs[2] == 1;
      if (wr_en) begin m_out = wr_data; m_of = 1; end
      else if (afell) m_of = 0;
      if (sfell) begin m_in = pad_in; m_if = 1; end
      else if (rd_en) m_if = 0;
      qa.push_front(ack_n); void'(qa.pop_back());
      qs.push_front(stb_n); void'(qs.pop_back());
    end
  end

  always @(negedge clk) if (rst_n) begin
    bit eoe;
    eoe = !qa[1] && qs[1];
    check("R3 oe", pad_oe, eoe);
    check("R4 pad", pad_out, eoe ? m_out : 0);
    check("R5 out_full", out_full, m_of);
    check("R7 in_full", in_full, m_if);
    check("R6 rd_data", rd_data, m_in);
    if (pad_oe && periph_en) check("R8 contention", 1, 0);
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cyc(2); rst_n = 1; cyc(1);
    check("R1 oe", pad_oe, 0); check("R1 pad", pad_out, 0);
    check("R1 of", out_full, 0); check("R1 if", in_full, 0);
    check("R1 rd", rd_data, 0);
    // R2
    wr_data = 8'hA5; wr_en = 1; cyc(1); wr_en = 0;
    check("R2 full", out_full, 1); check("R2 oe idle", pad_oe, 0);
    // R3 + R5
    ack_n = 0; cyc(1); check("R3 latency", pad_oe, 0);
    cyc(1); check("R3 oe", pad_oe, 1); check("R3 byte", pad_out, 8'hA5);
    cyc(1); check("R5 cleared", out_full, 0);
    wr_data = 8'h3C; wr_en = 1; cyc(1); wr_en = 0;
    check("R3 follow", pad_out, 8'h3C); check("R2 refill", out_full, 1);
    // R4
    ack_n = 1; cyc(3);
    check("R4 oe off", pad_oe, 0); check("R4 pad zero", pad_out, 0);
    // R6, R9
    periph_data = 8'h5A; periph_en = 1; cyc(1);
    stb_n = 0; cyc(4);
    check("R6 data", rd_data, 8'h5A); check("R6 full", in_full, 1);
    check("R9 out_full kept", out_full, 1);
    // R8: violation, ack low inside strobe
    ack_n = 0; cyc(3); check("R8 gated", pad_oe, 0);
    ack_n = 1; stb_n = 1; cyc(3); periph_en = 0; cyc(1);
    // R9: write leaves input reg
    wr_data = 8'h11; wr_en = 1; cyc(1); wr_en = 0; cyc(1);
    check("R9 rd_data kept", rd_data, 8'h5A);
    // R7
    rd_en = 1; cyc(1); rd_en = 0; check("R7 clear", in_full, 0);
    // R5 collision: write in the cycle the fall applies
    ack_n = 0; cyc(2); wr_data = 8'h77; wr_en = 1; cyc(1); wr_en = 0;
    check("R5 write wins", out_full, 1);
    ack_n = 1; cyc(4);
    // R7 collision: read in the capture cycle
    periph_data = 8'hC3; periph_en = 1; cyc(1);
    stb_n = 0; cyc(2); rd_en = 1; cyc(1); rd_en = 0;
    check("R7 capture wins", in_full, 1); check("R6 data2", rd_data, 8'hC3);
    stb_n = 1; cyc(3); periph_en = 0; cyc(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule